// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a countdown watchdog sitting on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. Software writes a tick count into the timer register. It then picks an expiry action in the control register. While an action is selected, the count falls by one every clock. When it runs out, the block emits a one-cycle pulse on the output that matches the action: a general interrupt, a non-maskable interrupt, or a chip-reset request. Writing the timer register again before expiry is the keep-alive.

A timer write does not reach the counter at once. It travels through a fixed pipeline of `LOAD_LAT` clocks, which models the slow internal update of the count. Software must let that delay pass before it arms an action. A cause flag records that the watchdog requested a chip reset. That flag is cleared only by the power-on reset (`por_n`), so it survives the functional reset (`rst_n`) that the request triggers. At power-on both resets are asserted together.

Top module: `wdog_action_top`

## Requirements
- R1: After reset the control register reads 0, the timer register reads 0 and all three pulse outputs are low.
- R2: The control register sits at offset 0x00. Its bits [1:0] hold the action: 0 none, 1 interrupt, 2 non-maskable interrupt, 3 chip-reset request. Bit 31 is the read-only reset-cause flag. Every other bit reads 0 and ignores writes.
- R3: A write to the timer register (offset 0x04) replaces the count exactly `LOAD_LAT` (default 3) clock edges after the write edge. Reads made before then return the old count.
- R4: When the action is non-zero, the count falls by one at each clock edge, starting with the first edge after the action write. It stops at zero.
- R5: When the action is 0, the count holds its value and no pulse output is raised.
- R6: At the edge where the count steps from 1 to 0 under a non-zero action, exactly one output goes high for exactly one cycle. Action 1 selects `irq_pulse`, action 2 selects `nmi_pulse` and action 3 selects `chip_rst_req`.
- R7: Rewriting the timer register often enough prevents any pulse. Once the rewrites stop, one pulse follows.
- R8: The reset-cause flag is set in the same cycle as `chip_rst_req`. It keeps its value through `rst_n` and is cleared only by `por_n`.
- R9: Writes to any offset other than 0x00 and 0x04 change nothing, and reads of such offsets return 0.
- R10: A timer read returns the live remaining count. The full value 0xFFFFFFFF loads and counts down correctly.
- R11: Arming an action while the count is already 0, or loading a count of 0, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one watchdog tick per cycle |
| rst_n | input | 1 | Active-low async functional reset (registers, counter, pipeline) |
| por_n | input | 1 | Active-low async power-on reset; the only clear of the cause flag |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle expiry pulse for action 1 |
| nmi_pulse | output | 1 | One-cycle expiry pulse for action 2 |
| chip_rst_req | output | 1 | One-cycle expiry pulse for action 3 |

## Verification
A counter that decrements wrongly or stalls shows up first in the timer readback. It then shows in the cycle index of the expiry pulse, which the bench measures to the exact edge after arming. A load pipeline of the wrong depth shows in the cycle where the readback switches to the new value. A wrong action latch or pulse decode lights the wrong output, or holds an output for more than one cycle, on the same clock as the count reaches zero. A cause flag with the wrong reset hookup shows up in the first control read after `rst_n` or `por_n`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_IRQ     = 2'd1,
    ACT_NMI     = 2'd2,
    ACT_CHIPRST = 2'd3
  } wdog_act_e;

  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned TIMER_OFS = 4;
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              cause_flag,
  output wdog_act_e         action,
  output logic              load_req,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned FLAG_BIT = DATA_W - 1;

  logic sel_ctrl, sel_timer;

  assign sel_ctrl  = (addr == ADDR_W'(CTRL_OFS));
  assign sel_timer = (addr == ADDR_W'(TIMER_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) action <= ACT_NONE;
    else if (we && sel_ctrl) action <= wdog_act_e'(wdata[1:0]);
  end

  assign load_req = we && sel_timer;
  assign load_val = wdata;

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[1:0]      = action;
      rdata[FLAG_BIT] = cause_flag;
    end else if (sel_timer) begin
      rdata = cnt;
    end
  end

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel_ctrl) |=> $stable(action));
endmodule

// File: rtl/wdog_load_pipe.sv
module wdog_load_pipe #(
  parameter int unsigned LAT = 3,
  parameter int unsigned W   = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_val,
  output logic         out_vld,
  output logic [W-1:0] out_val
);
  logic [LAT-1:0] vld_q;
  logic [W-1:0]   val_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= 1'b0;
      val_q[0] <= '0;
    end else begin
      vld_q[0] <= in_vld;
      val_q[0] <= in_val;
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        val_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_q[g-1];
        val_q[g] <= val_q[g-1];
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_val = val_q[LAT-1];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wdog_act_e    action,
  input  logic         load_vld,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         fire
);
  logic armed;

  assign armed = (action != ACT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load_vld) cnt <= load_val;
    else if (armed && cnt != '0) cnt <= cnt - W'(1);
  end

  assign fire = armed && !load_vld && (cnt == W'(1));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load_vld && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));
  // R4
  stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_vld && cnt == '0) |=> (cnt == '0));
  // R5
  disarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load_vld) |=> $stable(cnt));
  // R3
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |=> (cnt == $past(load_val)));
endmodule

// File: rtl/wdog_action_dec.sv
module wdog_action_dec
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      por_n,
  input  logic      fire,
  input  wdog_act_e action,
  output logic      irq_pulse,
  output logic      nmi_pulse,
  output logic      chip_rst_req,
  output logic      cause_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse    <= 1'b0;
      nmi_pulse    <= 1'b0;
      chip_rst_req <= 1'b0;
    end else begin
      irq_pulse    <= fire && (action == ACT_IRQ);
      nmi_pulse    <= fire && (action == ACT_NMI);
      chip_rst_req <= fire && (action == ACT_CHIPRST);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause_flag <= 1'b0;
    else if (fire && action == ACT_CHIPRST) cause_flag <= 1'b1;
  end

  // R6
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_pulse, nmi_pulse, chip_rst_req}));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |=> !nmi_pulse);
  // R8
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    chip_rst_req |-> cause_flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    cause_flag |=> cause_flag);
endmodule

// File: rtl/wdog_action_top.sv
module wdog_action_top
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LOAD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse,
  output logic              nmi_pulse,
  output logic              chip_rst_req
);
  wdog_act_e         action;
  logic              load_req, load_vld, fire, cause_flag;
  logic [DATA_W-1:0] load_val, load_out, cnt;

  wdog_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regif_i (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .cnt(cnt), .cause_flag(cause_flag), .action(action),
    .load_req(load_req), .load_val(load_val), .rdata(reg_rdata)
  );

  wdog_load_pipe #(.LAT(LOAD_LAT), .W(DATA_W)) pipe_i (
    .clk(clk), .rst_n(rst_n), .in_vld(load_req), .in_val(load_val),
    .out_vld(load_vld), .out_val(load_out)
  );

  wdog_counter #(.W(DATA_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .action(action), .load_vld(load_vld),
    .load_val(load_out), .cnt(cnt), .fire(fire)
  );

  wdog_action_dec dec_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .fire(fire), .action(action),
    .irq_pulse(irq_pulse), .nmi_pulse(nmi_pulse),
    .chip_rst_req(chip_rst_req), .cause_flag(cause_flag)
  );
endmodule

// File: tb/wdog_action_top_tb_top.sv
`timescale 1ns/1ps
module wdog_action_top_tb_top;
  localparam logic [7:0] A_CTRL = 8'h00, A_TIMER = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse, nmi_pulse, chip_rst_req;

  int tests = 0, fails = 0;
  int irq_seen = 0, nmi_seen = 0, rst_seen = 0;

  always #2 clk = ~clk;

  wdog_action_top dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
    .nmi_pulse(nmi_pulse), .chip_rst_req(chip_rst_req)
  );

  always @(negedge clk) begin
    if (irq_pulse) irq_seen++;
    if (nmi_pulse) nmi_seen++;
    if (chip_rst_req) rst_seen++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = '0;
  endtask

  // watches n cycles; reports first pulse index and per-output high-cycle counts
  task automatic watch(int n, output int first, output int ni, output int nn, output int nr);
    first = -1; ni = 0; nn = 0; nr = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (irq_pulse) ni++;
      if (nmi_pulse) nn++;
      if (chip_rst_req) nr++;
      if (first < 0 && (irq_pulse || nmi_pulse || chip_rst_req)) first = i;
    end
  endtask

  task automatic load_and_wait(logic [31:0] v);
    bus_wr(A_TIMER, v);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
    bus_rd(A_TIMER, d); chk("R1 timer", d, 0);
    chk("R1 outputs", {29'd0, irq_pulse, nmi_pulse, chip_rst_req}, 0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    bus_wr(A_TIMER, 32'd20);
    repeat (2) @(negedge clk);
    bus_rd(A_TIMER, d); chk("R3 before landing", d, 0);
    @(negedge clk);
    bus_rd(A_TIMER, d); chk("R3 after landing", d, 20);
    repeat (4) @(negedge clk);
    bus_rd(A_TIMER, d); chk("R5 hold while disarmed", d, 20);
  endtask

  task automatic t_irq();
    logic [31:0] d; int f, a, b, c;
    load_and_wait(32'd10);
    bus_wr(A_CTRL, 32'd1);
    watch(4, f, a, b, c);
    bus_rd(A_TIMER, d); chk("R4 decrement", d, 6);
    watch(11, f, a, b, c);
    chk("R6 irq index", f, 6);
    chk("R6 irq one cycle", a, 1);
    chk("R6 irq only", b + c, 0);
    bus_rd(A_TIMER, d); chk("R4 stop at zero", d, 0);
    bus_wr(A_CTRL, 32'd0);
  endtask

  task automatic t_nmi();
    logic [31:0] d; int f, a, b, c;
    load_and_wait(32'd5);
    bus_wr(A_CTRL, 32'd2);
    watch(10, f, a, b, c);
    chk("R6 nmi index", f, 5);
    chk("R6 nmi one cycle", b, 1);
    chk("R6 nmi only", a + c, 0);
    bus_rd(A_CTRL, d); chk("R2 ctrl action readback", d, 2);
    bus_wr(A_CTRL, 32'd0);
  endtask

  task automatic t_keepalive();
    int i0, f, a, b, c;
    load_and_wait(32'd8);
    bus_wr(A_CTRL, 32'd1);
    #1 i0 = irq_seen;
    for (int k = 0; k < 6; k++) begin
      bus_wr(A_TIMER, 32'd8);
      repeat (2) @(negedge clk);
    end
    #1 chk("R7 no pulse while fed", irq_seen - i0, 0);
    watch(20, f, a, b, c);
    chk("R7 pulse after feeding stops", a, 1);
    bus_wr(A_CTRL, 32'd0);
  endtask

  task automatic t_disable();
    logic [31:0] d; int f, a, b, c;
    load_and_wait(32'd6);
    bus_wr(A_CTRL, 32'd1);
    watch(3, f, a, b, c);
    bus_rd(A_TIMER, d); chk("R4 partial count", d, 3);
    bus_wr(A_CTRL, 32'd0);
    watch(10, f, a, b, c);
    chk("R5 no pulse after disable", a + b + c, 0);
    bus_rd(A_TIMER, d); chk("R5 count frozen", d, 1);
  endtask

  task automatic t_zero_arm();
    logic [31:0] d; int f, a, b, c;
    load_and_wait(32'd0);
    bus_rd(A_TIMER, d); chk("R11 zero loaded", d, 0);
    bus_wr(A_CTRL, 32'd3);
    watch(10, f, a, b, c);
    chk("R11 no pulse from zero", a + b + c, 0);
    bus_rd(A_CTRL, d); chk("R11 flag untouched", d, 3);
    bus_wr(A_CTRL, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h05, 32'h0000_0007);
    repeat (4) @(negedge clk);
    bus_rd(A_CTRL, d);  chk("R9 ctrl unchanged", d, 0);
    bus_rd(A_TIMER, d); chk("R9 timer unchanged", d, 0);
    bus_rd(8'h08, d);   chk("R9 unmapped read 0x08", d, 0);
    bus_rd(8'h05, d);   chk("R9 unmapped read 0x05", d, 0);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    bus_wr(A_CTRL, 32'hFFFF_FFFC);
    bus_rd(A_CTRL, d); chk("R2 upper bits ignored, flag read-only", d, 0);
  endtask

  task automatic t_max();
    logic [31:0] d; int f, a, b, c;
    load_and_wait(32'hFFFF_FFFF);
    bus_rd(A_TIMER, d); chk("R10 max load", d, 32'hFFFF_FFFF);
    bus_wr(A_CTRL, 32'd1);
    watch(5, f, a, b, c);
    bus_rd(A_TIMER, d); chk("R10 live count", d, 32'hFFFF_FFFA);
    bus_wr(A_CTRL, 32'd0);
  endtask

  task automatic t_chip_reset();
    logic [31:0] d; int f, a, b, c;
    load_and_wait(32'd3);
    bus_wr(A_CTRL, 32'd3);
    watch(6, f, a, b, c);
    chk("R6 chip reset index", f, 3);
    chk("R6 chip reset one cycle", c, 1);
    chk("R6 chip reset only", a + b, 0);
    bus_rd(A_CTRL, d); chk("R8 flag set", d, 32'h8000_0003);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_rd(A_CTRL, d);  chk("R8 flag survives rst_n", d, 32'h8000_0000);
    bus_rd(A_TIMER, d); chk("R8 timer cleared by rst_n", d, 0);
    @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
    bus_rd(A_CTRL, d); chk("R8 flag cleared by por_n", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_irq();
        t_nmi();
        t_keepalive();
        t_disable();
        t_zero_arm();
        bus_wr(A_TIMER, 32'd0);
        repeat (4) @(negedge clk);
        t_unmapped();
        t_ctrl_bits();
        t_max();
        t_chip_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule